// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block is the control core that sits behind the serial register interface of a multi-output clock generator. It holds four configuration bytes, each with its own power-up value, and turns them into one level enable per clock output: twelve differential outputs and four single-ended ones. It also produces a down-spread request, two frequency-select codes and a PLL power-down request. An active-low hardware power pin, `hw_pwr_n`, overrides all of it. When the pin is low, the register file returns to its defaults and every output is switched off.

A control byte chooses who owns global enable. In hardware mode the synchronized pin decides. In software mode a register bit decides, and that bit can switch all outputs off. A three-state machine handles every move from global-off to global-on. In `ST_OFF` the PLLs are held down. After transition `T_WAKE`, the machine waits in `ST_SETTLE` for `SETTLE_CYCLES` clocks. After transition `T_READY`, it is in `ST_RUN`, and only there do the individual enables reach the outputs. Transition `T_DROP` leads back to `ST_OFF` from either `ST_SETTLE` or `ST_RUN` whenever global enable falls.

Register index and bit layout:
- Index 0:
  - bit 7: spread enable.
  - bit 6: control source (1 = software).
  - bit 5: software global enable.
  - bits 4:1: 50 MHz select code.
  - bit 0: enable of the second 50 MHz output.
- Index 1:
  - bit 7: 32.256 MHz enable.
  - bit 6: first 50 MHz enable.
  - bit 5: selectable-rate output enable.
  - bits 4..0: differential outputs 11..7.
- Index 2: bits 7:5 hold the selectable-rate code.
- Index 3: bits 7..1 enable differential outputs 6..0.

Top module: `oe_ctrl_top`

## Requirements
- R1: After the power pin is released, reading index 0, 1, 2 and 3 returns 35h, F0h, 80h and 06h.
- R2: While `hw_pwr_n` is low, `pll_pd` is 1 and every bit of `diff_oe` and `se_oe` is 0, with no clock edge needed. All registers are held at their R1 values during this time.
- R3: After `hw_pwr_n` rises, `pll_pd` falls on the third rising clock edge. The output enables turn on on edge 3+`SETTLE_CYCLES` and not before.
- R4: In `ST_RUN` the enables follow the register bits. `diff_oe[k]` is index 3 bit k+1 for k = 0..6, and index 1 bit k-7 for k = 7..11. `se_oe[0]` is index 1 bit 6, `se_oe[1]` is index 0 bit 0, `se_oe[2]` is index 1 bit 5, and `se_oe[3]` is index 1 bit 7. Each bit takes effect on the edge that writes it.
- R5: `spread_en` equals index 0 bit 7, `fsel_a` equals index 0 bits 4:1, and `fsel_b` equals index 2 bits 7:5.
- R6: With index 0 bit 6 = 1 and bit 5 = 0, on the edge after the write `pll_pd` is 1 and every enable is 0.
- R7: Setting index 0 bit 5 back to 1 in software mode holds all enables low for `SETTLE_CYCLES` edges after the write edge. They turn on at the next edge, and `pll_pd` is 0 during the wait.
- R8: With index 0 bit 6 = 0, index 0 bit 5 has no effect on the output enables.
- R9: Index 2 bits 4:0 and index 3 bit 0 always read 0. Writes to an index above 3 change no register and no output, and such indices read 00h.
- R10: A global-enable drop during `ST_SETTLE` returns to `ST_OFF`. The next enable waits a full `SETTLE_CYCLES` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_pwr_n | input | 1 | Asynchronous active-low power-down and register reset pin |
| wr_en | input | 1 | Register write strobe from the serial slave |
| addr | input | ADDR_W | Register index for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| diff_oe | output | 12 | Per-output enables of the differential outputs |
| se_oe | output | 4 | Per-output enables of the single-ended outputs |
| spread_en | output | 1 | Down-spread request for the differential outputs |
| fsel_a | output | 4 | Frequency-select code of the 50 MHz pair |
| fsel_b | output | 3 | Frequency-select code of the selectable-rate output |
| pll_pd | output | 1 | PLL power-down request |

## Verification
The bench builds the block with `SETTLE_CYCLES` = 5 and the default two-stage pin synchronizer. This keeps the wake-up window short enough to count edge by edge, both after the pin is released and after a software re-enable. A window of five cycles also leaves room to drop global enable in the middle of `ST_SETTLE` and then confirm that the count starts again from zero. The exact edge where enables first appear is checked against 3+`SETTLE_CYCLES` for a pin release and 1+`SETTLE_CYCLES` for a register write.

// File: rtl/oe_ctrl_pkg.sv
package oe_ctrl_pkg;

    localparam int NUM_DIFF = 12;
    localparam int NUM_SE   = 4;

    localparam logic [7:0] DEF_IDX0 = 8'h35;
    localparam logic [7:0] DEF_IDX1 = 8'hF0;
    localparam logic [7:0] DEF_IDX2 = 8'h80;
    localparam logic [7:0] DEF_IDX3 = 8'h06;

    // writable bits; the rest read as zero
    localparam logic [7:0] MASK_IDX2 = 8'hE0;
    localparam logic [7:0] MASK_IDX3 = 8'hFE;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } wake_state_t;

    typedef struct packed {
        logic                spread;
        logic                sw_mode;
        logic                sw_on;
        logic [3:0]          code_a;
        logic [2:0]          code_b;
        logic [NUM_DIFF-1:0] diff_bits;
        logic [NUM_SE-1:0]   se_bits;
    } ctl_t;

endpackage

// File: rtl/oe_pin_sync.sv
module oe_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_ok
);

    logic [STAGES-1:0] chain;

    // asynchronous assertion, synchronous release
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign pin_ok = chain[STAGES-1];

endmodule

// File: rtl/oe_regfile.sv
module oe_regfile
    import oe_ctrl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output ctl_t              ctl
);

    localparam logic [ADDR_W-1:0] IDX0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] IDX1 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] IDX2 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] IDX3 = ADDR_W'(3);

    logic [7:0] reg0, reg1, reg2, reg3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg0 <= DEF_IDX0;
            reg1 <= DEF_IDX1;
            reg2 <= DEF_IDX2;
            reg3 <= DEF_IDX3;
        end else if (wr_en) begin
            case (addr)
                IDX0:    reg0 <= wdata;
                IDX1:    reg1 <= wdata;
                IDX2:    reg2 <= wdata & MASK_IDX2;
                IDX3:    reg3 <= wdata & MASK_IDX3;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            IDX0:    rdata = reg0;
            IDX1:    rdata = reg1;
            IDX2:    rdata = reg2;
            IDX3:    rdata = reg3;
            default: rdata = 8'h00;
        endcase
    end

    assign ctl.spread  = reg0[7];
    assign ctl.sw_mode = reg0[6];
    assign ctl.sw_on   = reg0[5];
    assign ctl.code_a  = reg0[4:1];
    assign ctl.code_b  = reg2[7:5];

    // differential enables: low seven from index 3, high five from index 1
    for (genvar k = 0; k < NUM_DIFF; k++) begin : g_diff_map
        if (k < 7) begin : g_lo
            assign ctl.diff_bits[k] = reg3[k+1];
        end else begin : g_hi
            assign ctl.diff_bits[k] = reg1[k-7];
        end
    end

    assign ctl.se_bits[0] = reg1[6];
    assign ctl.se_bits[1] = reg0[0];
    assign ctl.se_bits[2] = reg1[5];
    assign ctl.se_bits[3] = reg1[7];

    // R9
    rsvd_idx_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > IDX3) |=> $stable({reg0, reg1, reg2, reg3}));

    // R5
    idx0_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == IDX0) |=> (ctl.code_a == $past(wdata[4:1])));

endmodule

// File: rtl/oe_settle_fsm.sv
module oe_settle_fsm
    import oe_ctrl_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic glob_en,
    output logic run,
    output logic pd_req
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(SETTLE_CYCLES - 1);

    wake_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:    if (glob_en) state_nx = ST_SETTLE;           // T_WAKE
            ST_SETTLE: if (!glob_en) state_nx = ST_OFF;             // T_DROP
                       else if (cnt == LIM) state_nx = ST_RUN;      // T_READY
            ST_RUN:    if (!glob_en) state_nx = ST_OFF;             // T_DROP
            default:   state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SETTLE && state_nx == ST_SETTLE) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    always_comb begin
        run    = 1'b0;
        pd_req = 1'b0;
        unique case (state)
            ST_OFF:    pd_req = 1'b1;
            ST_SETTLE: ;
            ST_RUN:    run = 1'b1;
            default:   pd_req = 1'b1;
        endcase
    end

    // R3
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && cnt != LIM) |=> (state != ST_RUN));

    // R6
    drop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en) |=> (state == ST_OFF));

    // R10
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> (state != ST_RUN));

endmodule

// File: rtl/oe_ctrl_top.sv
module oe_ctrl_top
    import oe_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 3,
    parameter int SETTLE_CYCLES = 1000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                hw_pwr_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic [NUM_DIFF-1:0] diff_oe,
    output logic [NUM_SE-1:0]   se_oe,
    output logic                spread_en,
    output logic [3:0]          fsel_a,
    output logic [2:0]          fsel_b,
    output logic                pll_pd
);

    logic pin_ok;
    ctl_t ctl;
    logic glob_en;
    logic run;

    oe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .pin_n  (hw_pwr_n),
        .pin_ok (pin_ok)
    );

    oe_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (pin_ok),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ctl   (ctl)
    );

    // software mode ignores the pin; hardware mode follows it
    assign glob_en = ctl.sw_mode ? ctl.sw_on : pin_ok;

    oe_settle_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (pin_ok),
        .glob_en (glob_en),
        .run     (run),
        .pd_req  (pll_pd)
    );

    assign diff_oe   = run ? ctl.diff_bits : '0;
    assign se_oe     = run ? ctl.se_bits   : '0;
    assign spread_en = ctl.spread;
    assign fsel_a    = ctl.code_a;
    assign fsel_b    = ctl.code_b;

    // R2
    pd_gate_chk: assert property (@(posedge clk) disable iff (!pin_ok)
        pll_pd |-> (diff_oe == '0 && se_oe == '0));

    // R4
    run_follow_chk: assert property (@(posedge clk) disable iff (!pin_ok)
        (!pll_pd && diff_oe != '0) |-> (diff_oe == ctl.diff_bits));

endmodule

// File: tb/tb_oe_ctrl_top.sv
module tb_oe_ctrl_top;

    localparam int CLK_PERIOD = 10;
    localparam int S          = 5;

    typedef struct packed {
        logic [2:0]  a;
        logic [7:0]  d;
        logic [11:0] diff;
        logic [3:0]  se;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{3'd1, 8'h00, 12'h003, 4'b0010},
        '{3'd3, 8'hFE, 12'h07F, 4'b0010},
        '{3'd1, 8'h1F, 12'hFFF, 4'b0010},
        '{3'd0, 8'h34, 12'hFFF, 4'b0000},
        '{3'd1, 8'hE0, 12'h07F, 4'b1101},
        '{3'd3, 8'h00, 12'h000, 4'b1101},
        '{3'd3, 8'hAA, 12'h055, 4'b1101},
        '{3'd1, 8'h15, 12'hAD5, 4'b0000},
        '{3'd0, 8'h01, 12'hAD5, 4'b0010},
        '{3'd5, 8'hFF, 12'hAD5, 4'b0010}
    };

    logic        clk = 1'b0;
    logic        hw_pwr_n;
    logic        wr_en;
    logic [2:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [11:0] diff_oe;
    logic [3:0]  se_oe;
    logic        spread_en;
    logic [3:0]  fsel_a;
    logic [2:0]  fsel_b;
    logic        pll_pd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oe_ctrl_top #(.ADDR_W(3), .SETTLE_CYCLES(S), .SYNC_STAGES(2)) dut (
        .clk(clk), .hw_pwr_n(hw_pwr_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .diff_oe(diff_oe), .se_oe(se_oe),
        .spread_en(spread_en), .fsel_a(fsel_a), .fsel_b(fsel_b),
        .pll_pd(pll_pd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(req, {24'h0, rdata}, {24'h0, exp});
    endtask

    task automatic oe_chk(input string req, input logic [11:0] d, input logic [3:0] s);
        chk(req, {16'h0, se_oe, diff_oe}, {16'h0, s, d});
    endtask

    initial begin
        hw_pwr_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wdata = 8'h00;
        tick(3);
        // R2 reset state
        chk("R2 pll_pd in reset", {31'h0, pll_pd}, 32'h1);
        oe_chk("R2 oe in reset", 12'h000, 4'b0000);

        // R3 release timing
        hw_pwr_n = 1'b1;
        tick(2);
        chk("R3 pll_pd held after edge 2", {31'h0, pll_pd}, 32'h1);
        tick(1);
        chk("R3 pll_pd released at edge 3", {31'h0, pll_pd}, 32'h0);
        tick(S - 1);
        oe_chk("R3 oe still off at edge 2+S", 12'h000, 4'b0000);
        tick(1);
        oe_chk("R3 oe on at edge 3+S", 12'h803, 4'b1111);

        // R1 defaults
        rd_chk("R1 idx0", 3'd0, 8'h35);
        rd_chk("R1 idx1", 3'd1, 8'hF0);
        rd_chk("R1 idx2", 3'd2, 8'h80);
        rd_chk("R1 idx3", 3'd3, 8'h06);
        addr = 3'd0;
        chk("R5 default fsel_a", {28'h0, fsel_a}, 32'hA);
        chk("R5 default fsel_b", {29'h0, fsel_b}, 32'h4);
        chk("R5 default spread", {31'h0, spread_en}, 32'h0);

        // R4 / R8 / R9 vector walk
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i].a, VEC[i].d);
            oe_chk($sformatf("R4 R8 R9 vector %0d", i), VEC[i].diff, VEC[i].se);
        end
        rd_chk("R9 idx5 reads zero", 3'd5, 8'h00);
        addr = 3'd0;

        // R5 codes and R9 reserved bits
        @(negedge clk);
        wr(3'd0, 8'h8C);
        chk("R5 spread_en", {31'h0, spread_en}, 32'h1);
        chk("R5 fsel_a", {28'h0, fsel_a}, 32'h6);
        wr(3'd2, 8'hFF);
        chk("R5 fsel_b", {29'h0, fsel_b}, 32'h7);
        wr(3'd3, 8'hFF);
        rd_chk("R9 idx2 reserved", 3'd2, 8'hE0);
        rd_chk("R9 idx3 reserved", 3'd3, 8'hFE);
        addr = 3'd0;
        oe_chk("R4 full low group", 12'hAFF, 4'b0000);

        // R6 software disable
        @(negedge clk);
        wr(3'd0, 8'h41);
        tick(1);
        chk("R6 pll_pd on sw disable", {31'h0, pll_pd}, 32'h1);
        oe_chk("R6 oe off on sw disable", 12'h000, 4'b0000);

        // R7 software re-enable
        wr(3'd0, 8'h61);
        tick(S);
        chk("R7 pll_pd low while settling", {31'h0, pll_pd}, 32'h0);
        oe_chk("R7 oe off while settling", 12'h000, 4'b0000);
        tick(1);
        oe_chk("R7 oe on after settle", 12'hAFF, 4'b0010);

        // R10 drop mid-settle restarts count
        wr(3'd0, 8'h41);
        tick(1);
        wr(3'd0, 8'h61);
        tick(2);
        wr(3'd0, 8'h41);
        tick(1);
        chk("R10 back to off", {31'h0, pll_pd}, 32'h1);
        wr(3'd0, 8'h61);
        tick(S);
        oe_chk("R10 full wait repeated", 12'h000, 4'b0000);
        tick(1);
        oe_chk("R10 on after full wait", 12'hAFF, 4'b0010);

        // R2 pin drop mid-run, asynchronous
        #2;
        hw_pwr_n = 1'b0;
        #1;
        chk("R2 async pll_pd", {31'h0, pll_pd}, 32'h1);
        oe_chk("R2 async oe off", 12'h000, 4'b0000);
        tick(3);
        rd_chk("R2 idx0 back to default", 3'd0, 8'h35);
        rd_chk("R2 idx3 back to default", 3'd3, 8'h06);
        addr = 3'd0;
        @(negedge clk);
        hw_pwr_n = 1'b1;
        tick(3 + S);
        oe_chk("R1 R3 defaults after second release", 12'h803, 4'b1111);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule